// File: doc/BRIEF.md
# Transmit Packet Queue

This block is the host-facing transmit buffer of an Ethernet MAC. Software pushes frame data into a deep word FIFO one 32-bit word at a time. It then commits a frame by writing a command word that gives the frame length in bytes and the byte position of the first valid byte inside the first data word. Committed frames wait in a small command queue. A downstream transmitter reads the command, then pulls exactly the data words that command covers, through a simple valid/pop consumer port.

Software can read the fill level, program the almost-empty and almost-full watermarks, and hold both queues empty with a flush bit. Five transmit events are latched into an interrupt source register that clears when read. An enable register masks those events and gates the interrupt line with a global enable. Words written before their command arrives are called pending. The consumer cannot see pending words, and if a command asks for more words than are pending, the command and the pending words are thrown away together.

Top module: `tx_pkt_queue`

## Requirements
- R1: A register write to offset 0x00C appends one 32-bit word to the data FIFO (DEPTH = 1024 words). Offset 0x130 reads the stored word count in bits 10:0 and the number of queued commands in bits 20:16.
- R2: A register write to offset 0x008 is a frame command: byte length in bits 15:0, first-byte offset in bits 17:16. The frame occupies (length + offset + 3) / 4 words. An accepted command appears on the consumer port (cmd_valid, cmd_len, cmd_ofs) and does not change the word count.
- R3: A data write while 1024 words are stored is dropped, leaves the count unchanged, and sets source bit 4 (FIFO full).
- R4: A command whose word need exceeds the pending (uncommitted) words, or which arrives while the command queue is full, is dropped. The pending words are removed and source bit 3 (discarded frame) is set.
- R5: The consumer sees only committed words (word_valid), in write order. Each word_pop removes one word. A cmd_pop removes the head command and sets source bit 0 (packet sent).
- R6: Offset 0x120 holds the almost-empty threshold in bits 10:0 (reset 384) and the almost-full threshold in bits 26:16 (reset 640). Source bit 2 is set in every cycle the count is below the almost-empty threshold. Source bit 1 is set in every cycle the count is above the almost-full threshold.
- R7: While bit 4 of offset 0x124 is set, both FIFOs are empty, and data writes, command writes and consumer pops are ignored.
- R8: Offset 0x104 returns the source bits 4:0 and clears them on read. A source event in the same cycle as the read stays set for the next read.
- R9: Offset 0x108 holds the per-source enables in bits 4:0, a summary enable in bit 16 and a global enable in bit 18. irq is high when the global enable is set and any enabled source bit is set. Source read bit 16 shows that same any-enabled condition when the summary enable is set.
- R10: After reset the FIFOs are empty, the source and enable registers are zero, flush is clear, irq is low and the thresholds hold their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the source register) |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| cmd_valid | output | 1 | A committed frame command is available |
| cmd_len | output | 16 | Head command byte length |
| cmd_ofs | output | 2 | Head command first-byte offset |
| cmd_pop | input | 1 | Remove the head command |
| word_valid | output | 1 | A committed data word is available |
| word_data | output | 32 | Oldest committed data word |
| word_pop | input | 1 | Remove the oldest committed word |
| irq | output | 1 | Interrupt request |

## Verification
The command path is driven with a table of length, offset and word-count combinations. Each case sits just at or just past the word need of the rounding formula, so a wrong offset term or a wrong rounding splits accepted frames from discarded ones. Directed sequences then cover four things:
- filling to exactly 1024 words and one word past it, which separates the drop path from wrap-around;
- moving the watermarks so both level events switch on and off;
- a source read in the same cycle as a pop, which separates clear-then-set from set-then-clear;
- a flush with writes made while it is held.

// File: rtl/txq_pkg.sv
package txq_pkg;
    localparam int unsigned WORD_W = 32;

    localparam logic [11:0] OFS_CMD  = 12'h008;
    localparam logic [11:0] OFS_DATA = 12'h00C;
    localparam logic [11:0] OFS_SRC  = 12'h104;
    localparam logic [11:0] OFS_EN   = 12'h108;
    localparam logic [11:0] OFS_THR  = 12'h120;
    localparam logic [11:0] OFS_CTRL = 12'h124;
    localparam logic [11:0] OFS_WCNT = 12'h130;

    localparam int EV_SENT = 0;
    localparam int EV_AF   = 1;
    localparam int EV_AE   = 2;
    localparam int EV_DISC = 3;
    localparam int EV_FULL = 4;
    localparam int NUM_EV  = 5;

    localparam int EN_SUMM_BIT = 16;
    localparam int EN_GLOB_BIT = 18;
    localparam int CTRL_FLUSH_BIT = 4;

    typedef struct packed {
        logic [1:0]  ofs;
        logic [15:0] len;
    } txq_cmd_t;
endpackage

// File: rtl/txq_data_ram.sv
module txq_data_ram #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/txq_cmd_fifo.sv
module txq_cmd_fifo
    import txq_pkg::*;
#(
    parameter int CDEPTH = 16,
    localparam int CAW = $clog2(CDEPTH),
    localparam int CCW = CAW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           flush,
    input  logic           push,
    input  txq_cmd_t       push_cmd,
    input  logic           pop,
    output logic           full,
    output logic           valid,
    output txq_cmd_t       head,
    output logic [CCW-1:0] count
);
    typedef struct packed {
        logic [CAW-1:0] wp;
        logic [CAW-1:0] rp;
        logic [CCW-1:0] cnt;
    } cq_state_t;

    cq_state_t st_d, st_q;
    txq_cmd_t  mem [CDEPTH];
    logic      do_push, do_pop;

    always_comb begin
        do_push = push && !full && !flush;
        do_pop  = pop && valid && !flush;
        st_d    = st_q;
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            st_d.wp  = st_q.wp + CAW'(do_push);
            st_d.rp  = st_q.rp + CAW'(do_pop);
            st_d.cnt = st_q.cnt + CCW'(do_push) - CCW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[st_q.wp] <= push_cmd;
        end
    end

    assign full  = (st_q.cnt == CCW'(CDEPTH));
    assign valid = (st_q.cnt != '0);
    assign head  = mem[st_q.rp];
    assign count = st_q.cnt;

    // R4: the command queue never holds more than its depth
    assert_cmdq_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CCW'(CDEPTH));

    // R7: a held flush leaves the command queue empty on the next cycle
    assert_cmdq_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.cnt == '0));
endmodule

// File: rtl/txq_irq.sv
module txq_irq
    import txq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev,
    input  logic              rd_clr,
    input  logic              en_we,
    input  logic [31:0]       en_wdata,
    output logic [NUM_EV-1:0] src,
    output logic [NUM_EV-1:0] mask,
    output logic              summ_en,
    output logic              glob_en,
    output logic              any_pend,
    output logic              irq
);
    typedef struct packed {
        logic [NUM_EV-1:0] src;
        logic [NUM_EV-1:0] mask;
        logic              summ;
        logic              glob;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.src = (rd_clr ? '0 : st_q.src) | ev;
        if (en_we) begin
            st_d.mask = en_wdata[NUM_EV-1:0];
            st_d.summ = en_wdata[EN_SUMM_BIT];
            st_d.glob = en_wdata[EN_GLOB_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign src      = st_q.src;
    assign mask     = st_q.mask;
    assign summ_en  = st_q.summ;
    assign glob_en  = st_q.glob;
    assign any_pend = |(st_q.src & st_q.mask);
    assign irq      = st_q.glob && any_pend;

    // R8: a read with no coincident event leaves the source register clear
    assert_clear_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && (ev == '0)) |=> (st_q.src == '0));

    // R8: an event is never lost, even in the cycle of a clearing read
    assert_event_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((st_q.src & $past(ev)) == $past(ev)));
endmodule

// File: rtl/tx_pkt_queue.sv
module tx_pkt_queue
    import txq_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int CDEPTH = 16,
    parameter int AE_DEF = 384,
    parameter int AF_DEF = 640,
    localparam int AW  = $clog2(DEPTH),
    localparam int CW  = AW + 1,
    localparam int CCW = $clog2(CDEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        cmd_valid,
    output logic [15:0] cmd_len,
    output logic [1:0]  cmd_ofs,
    input  logic        cmd_pop,
    output logic        word_valid,
    output logic [31:0] word_data,
    input  logic        word_pop,
    output logic        irq
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic [CW-1:0] pend;
        logic          flush;
        logic [CW-1:0] ae_th;
        logic [CW-1:0] af_th;
    } q_state_t;

    q_state_t st_d, st_q;

    logic              data_wr, cmd_wr, data_ok, data_drop;
    logic              cmd_ok, cmd_disc, pop_w, pop_c, full;
    logic              cq_full, cq_valid;
    logic [CCW-1:0]    cq_count;
    txq_cmd_t          new_cmd, cq_head;
    logic [17:0]       need_sum;
    logic [15:0]       need;
    logic              fits;
    logic [CW-1:0]     committed;
    logic [NUM_EV-1:0] ev, src, mask;
    logic              summ_en, glob_en, any_pend;

    // Command decode and word need
    always_comb begin
        new_cmd   = txq_cmd_t'(reg_wdata[17:0]);
        need_sum  = 18'(new_cmd.len) + 18'(new_cmd.ofs) + 18'd3;
        need      = need_sum[17:2];
        fits      = ({16'b0, need} <= 32'(st_q.pend));
        committed = st_q.cnt - st_q.pend;
        full      = (st_q.cnt == CW'(DEPTH));
        data_wr   = reg_wr && (reg_addr == OFS_DATA);
        cmd_wr    = reg_wr && (reg_addr == OFS_CMD);
        data_ok   = data_wr && !st_q.flush && !full;
        data_drop = data_wr && !st_q.flush && full;
        cmd_ok    = cmd_wr && !st_q.flush && fits && !cq_full;
        cmd_disc  = cmd_wr && !st_q.flush && !(fits && !cq_full);
        pop_w     = word_pop && (committed != '0) && !st_q.flush;
        pop_c     = cmd_pop && cq_valid && !st_q.flush;
    end

    // Next-state
    always_comb begin
        st_d = st_q;
        if (st_q.flush) begin
            st_d.wp   = '0;
            st_d.rp   = '0;
            st_d.cnt  = '0;
            st_d.pend = '0;
        end else begin
            st_d.wp   = st_q.wp + AW'(data_ok);
            st_d.rp   = st_q.rp + AW'(pop_w);
            st_d.cnt  = st_q.cnt + CW'(data_ok) - CW'(pop_w);
            st_d.pend = st_q.pend + CW'(data_ok);
            if (cmd_ok) begin
                st_d.pend = st_q.pend - CW'(need);
            end
            if (cmd_disc) begin
                st_d.wp   = st_q.wp - st_q.pend[AW-1:0];
                st_d.cnt  = st_q.cnt - st_q.pend - CW'(pop_w);
                st_d.pend = '0;
            end
        end
        if (reg_wr && (reg_addr == OFS_CTRL)) begin
            st_d.flush = reg_wdata[CTRL_FLUSH_BIT];
        end
        if (reg_wr && (reg_addr == OFS_THR)) begin
            st_d.ae_th = reg_wdata[CW-1:0];
            st_d.af_th = reg_wdata[16 +: CW];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.ae_th <= CW'(AE_DEF);
            st_q.af_th <= CW'(AF_DEF);
        end else begin
            st_q <= st_d;
        end
    end

    // Event vector for the interrupt logic
    always_comb begin
        ev          = '0;
        ev[EV_SENT] = pop_c;
        ev[EV_AF]   = (st_q.cnt > st_q.af_th);
        ev[EV_AE]   = (st_q.cnt < st_q.ae_th);
        ev[EV_DISC] = cmd_disc;
        ev[EV_FULL] = data_drop;
    end

    txq_data_ram #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_ram (
        .clk   (clk),
        .we    (data_ok),
        .waddr (st_q.wp),
        .wdata (reg_wdata),
        .raddr (st_q.rp),
        .rdata (word_data)
    );

    txq_cmd_fifo #(.CDEPTH(CDEPTH)) u_cmdq (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (st_q.flush),
        .push     (cmd_ok),
        .push_cmd (new_cmd),
        .pop      (pop_c),
        .full     (cq_full),
        .valid    (cq_valid),
        .head     (cq_head),
        .count    (cq_count)
    );

    txq_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .rd_clr   (reg_rd && (reg_addr == OFS_SRC)),
        .en_we    (reg_wr && (reg_addr == OFS_EN)),
        .en_wdata (reg_wdata),
        .src      (src),
        .mask     (mask),
        .summ_en  (summ_en),
        .glob_en  (glob_en),
        .any_pend (any_pend),
        .irq      (irq)
    );

    // Register read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_SRC: begin
                reg_rdata[NUM_EV-1:0]  = src;
                reg_rdata[EN_SUMM_BIT] = summ_en && any_pend;
            end
            OFS_EN: begin
                reg_rdata[NUM_EV-1:0]  = mask;
                reg_rdata[EN_SUMM_BIT] = summ_en;
                reg_rdata[EN_GLOB_BIT] = glob_en;
            end
            OFS_THR: begin
                reg_rdata[CW-1:0]   = st_q.ae_th;
                reg_rdata[16 +: CW] = st_q.af_th;
            end
            OFS_CTRL: reg_rdata[CTRL_FLUSH_BIT] = st_q.flush;
            OFS_WCNT: begin
                reg_rdata[CW-1:0]    = st_q.cnt;
                reg_rdata[16 +: CCW] = cq_count;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign cmd_valid  = cq_valid;
    assign cmd_len    = cq_head.len;
    assign cmd_ofs    = cq_head.ofs;
    assign word_valid = (committed != '0);

    // R3: the stored word count never exceeds the FIFO depth
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R3: a write into a full FIFO without a pop keeps the count
    assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_drop && !pop_w) |=> (st_q.cnt == $past(st_q.cnt)));

    // R4: pending words are always a subset of stored words
    assert_pend_within_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend <= st_q.cnt);

    // R4: a discarded command is flagged in the source register
    assert_discard_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_disc |=> src[EV_DISC]);

    // R7: while flush is held the data FIFO is empty one cycle later
    assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flush |=> (st_q.cnt == '0 && st_q.pend == '0));
endmodule

// File: tb/sim_tx_pkt_queue.sv
module sim_tx_pkt_queue;
    import txq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_valid;
    logic [15:0] cmd_len;
    logic [1:0]  cmd_ofs;
    logic        cmd_pop = 1'b0;
    logic        word_valid;
    logic [31:0] word_data;
    logic        word_pop = 1'b0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    tx_pkt_queue u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_valid(cmd_valid), .cmd_len(cmd_len), .cmd_ofs(cmd_ofs),
        .cmd_pop(cmd_pop), .word_valid(word_valid), .word_data(word_data),
        .word_pop(word_pop), .irq(irq)
    );

    // Stimulus table: {accept, words written, offset, length}
    localparam int NV = 8;
    localparam logic [28:0] VEC [NV] = '{
        {1'b1, 10'd2,  2'd0, 16'd8},
        {1'b0, 10'd2,  2'd0, 16'd9},
        {1'b1, 10'd3,  2'd3, 16'd9},
        {1'b1, 10'd1,  2'd3, 16'd1},
        {1'b0, 10'd1,  2'd3, 16'd2},
        {1'b1, 10'd17, 2'd2, 16'd64},
        {1'b1, 10'd17, 2'd1, 16'd64},
        {1'b0, 10'd16, 2'd2, 16'd64}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic do_flush();
        wr(OFS_CTRL, 32'h10);
        wr(OFS_CTRL, 32'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R10: reset state, read combinationally while reset is held
        repeat (3) @(negedge clk);
        reg_addr = OFS_SRC;  #1 chk("R10 src", reg_rdata, 32'h0);
        reg_addr = OFS_EN;   #1 chk("R10 en", reg_rdata, 32'h0);
        reg_addr = OFS_THR;  #1 chk("R10 thr", reg_rdata, {16'd640, 16'd384});
        reg_addr = OFS_WCNT; #1 chk("R10 wcnt", reg_rdata, 32'h0);
        reg_addr = OFS_CTRL; #1 chk("R10 ctrl", reg_rdata, 32'h0);
        chk("R10 irq", {31'b0, irq}, 32'h0);
        chk("R10 cmd_valid", {31'b0, cmd_valid}, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // R1: single data write counts
        wr(OFS_DATA, 32'h1234_5678);
        rd(OFS_WCNT, rv);
        chk("R1 wcnt one word", rv, 32'h1);

        // R2 / R4: command table
        for (int i = 0; i < NV; i++) begin
            logic        acc;
            logic [9:0]  nw;
            logic [1:0]  of;
            logic [15:0] ln;
            {acc, nw, of, ln} = VEC[i];
            do_flush();
            rd(OFS_SRC, rv);
            for (int k = 0; k < int'(nw); k++) wr(OFS_DATA, 32'(i * 256 + k));
            wr(OFS_CMD, {14'b0, of, ln});
            rd(OFS_WCNT, rv);
            if (acc) begin
                chk("R2 wcnt after accept", rv, {11'b0, 5'd1, 6'b0, nw});
                chk("R2 cmd_valid", {31'b0, cmd_valid}, 32'h1);
                chk("R2 cmd fields", {14'b0, cmd_ofs, cmd_len}, {14'b0, of, ln});
                rd(OFS_SRC, rv);
                chk("R2 no discard flag", {31'b0, rv[3]}, 32'h0);
            end else begin
                chk("R4 wcnt after discard", rv, 32'h0);
                chk("R4 no command queued", {31'b0, cmd_valid}, 32'h0);
                rd(OFS_SRC, rv);
                chk("R4 discard flag", {31'b0, rv[3]}, 32'h1);
            end
        end

        // R5: order, hidden pending words, sent flag
        do_flush();
        wr(OFS_DATA, 32'hA1); wr(OFS_DATA, 32'hB2); wr(OFS_DATA, 32'hC3);
        @(negedge clk); #1 chk("R5 pending hidden", {31'b0, word_valid}, 32'h0);
        wr(OFS_CMD, 32'd12);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1 chk("R5 word valid", {31'b0, word_valid}, 32'h1);
            chk("R5 word order", word_data, 32'hA1 + 32'(k) * 32'h11);
            word_pop = 1'b1;
            @(negedge clk); word_pop = 1'b0;
        end
        #1 chk("R5 drained", {31'b0, word_valid}, 32'h0);
        rd(OFS_SRC, rv);
        @(negedge clk); cmd_pop = 1'b1; @(negedge clk); cmd_pop = 1'b0;
        rd(OFS_SRC, rv);
        chk("R5 sent flag", {31'b0, rv[0]}, 32'h1);
        chk("R5 cmd removed", {31'b0, cmd_valid}, 32'h0);

        // R8: clear on read, and event coinciding with the read
        wr(OFS_CMD, 32'd40);
        rd(OFS_SRC, rv); chk("R8 first read sees discard", {31'b0, rv[3]}, 32'h1);
        rd(OFS_SRC, rv); chk("R8 second read cleared", {31'b0, rv[3]}, 32'h0);
        wr(OFS_DATA, 32'h55); wr(OFS_CMD, 32'd4);
        rd(OFS_SRC, rv);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = OFS_SRC; cmd_pop = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0; cmd_pop = 1'b0;
        rd(OFS_SRC, rv);
        chk("R8 same-cycle event kept", {31'b0, rv[0]}, 32'h1);
        @(negedge clk); word_pop = 1'b1; @(negedge clk); word_pop = 1'b0;

        // R6: thresholds
        do_flush();
        wr(OFS_THR, {16'd6, 16'd4});
        for (int k = 0; k < 5; k++) wr(OFS_DATA, 32'(k));
        rd(OFS_SRC, rv);
        rd(OFS_SRC, rv);
        chk("R6 not almost empty at 5", {30'b0, rv[2:1]}, 32'h0);
        wr(OFS_DATA, 32'h6); wr(OFS_DATA, 32'h7);
        rd(OFS_SRC, rv);
        chk("R6 almost full at 7", {31'b0, rv[1]}, 32'h1);
        do_flush();
        rd(OFS_SRC, rv);
        chk("R6 almost empty when empty", {31'b0, rv[2]}, 32'h1);
        wr(OFS_THR, {16'd640, 16'd384});

        // R7: flush ignores writes
        wr(OFS_DATA, 32'h1); wr(OFS_DATA, 32'h2);
        wr(OFS_CTRL, 32'h10);
        wr(OFS_DATA, 32'h3);
        rd(OFS_SRC, rv);
        wr(OFS_CMD, 32'd400);
        rd(OFS_WCNT, rv);
        chk("R7 empty while flushing", rv, 32'h0);
        rd(OFS_SRC, rv);
        chk("R7 command ignored", {31'b0, rv[3]}, 32'h0);
        wr(OFS_CTRL, 32'h0);
        rd(OFS_WCNT, rv);
        chk("R7 empty after flush", rv, 32'h0);

        // R3: fill to full and beyond
        for (int k = 0; k < 1024; k++) wr(OFS_DATA, 32'(k));
        rd(OFS_WCNT, rv);
        chk("R3 count at depth", rv, 32'd1024);
        rd(OFS_SRC, rv);
        chk("R3 no full flag yet", {31'b0, rv[4]}, 32'h0);
        wr(OFS_DATA, 32'hDEAD);
        rd(OFS_WCNT, rv);
        chk("R3 count unchanged", rv, 32'd1024);
        rd(OFS_SRC, rv);
        chk("R3 full flag", {31'b0, rv[4]}, 32'h1);
        chk("R6 almost full when full", {31'b0, rv[1]}, 32'h1);
        do_flush();

        // R9: enables, global gate and summary
        rd(OFS_SRC, rv);
        wr(OFS_EN, 32'h0004_0008);
        @(negedge clk); #1 chk("R9 masked level gives no irq", {31'b0, irq}, 32'h0);
        wr(OFS_CMD, 32'd8);
        #1 chk("R9 irq on enabled discard", {31'b0, irq}, 32'h1);
        rd(OFS_SRC, rv);
        chk("R9 summary off", {31'b0, rv[16]}, 32'h0);
        wr(OFS_EN, 32'h0005_0008);
        wr(OFS_CMD, 32'd8);
        rd(OFS_SRC, rv);
        chk("R9 summary on", {31'b0, rv[16]}, 32'h1);
        wr(OFS_EN, 32'h0001_0008);
        wr(OFS_CMD, 32'd8);
        #1 chk("R9 global gate", {31'b0, irq}, 32'h0);
        wr(OFS_EN, 32'h0004_0004);
        #1 chk("R9 almost-empty level irq", {31'b0, irq}, 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule